// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Four Memory Model

This block is a synthesizable storage model with a write-only data input and a read-only data output. Both ports share one address bus. Two active-low strobes request a read or a write, and they are sampled on the rising edge of the single clock. Every burst address selects a group of four words. Double-data-rate transfer is folded into one clock domain: each port moves two words per clock cycle, so a four-word burst lasts two cycles on either port. A read burst and a write burst can overlap freely, because each port has its own sequencer.

The address is split into two fields. The upper bits select the burst group, and the two lowest bits select the starting word. The burst then advances through the four word positions and wraps modulo four. Two active-low half-word enables per lane mask the write data, one for each 9-bit half. When a read beat and a write beat touch the same word on the same edge, the new data is forwarded, so a read always returns the most recent contents. Between read bursts the output is disabled: the valid flag is low and the data bus reads zero. The array contents are undefined after reset.

Top module: `qdr4_burst_mem`

## Requirements
- R1: While rst_ni is low, and after reset until a read is accepted, rvalid_o is 0 and rdata_o is all zeros.
- R2: When a write is accepted on edge E with start word s = addr_i[1:0] and group g = addr_i[ADDR_W-1:2], the data at edge E+1 is stored as follows: lane 0 (wdata_i[17:0]) goes to word (s+0) mod 4 and lane 1 (wdata_i[35:18]) goes to word (s+1) mod 4. At edge E+2 the lanes fill words (s+2) mod 4 and (s+3) mod 4.
- R3: A read accepted on edge E loads rdata_o on edge E+1 with words (s+0) and (s+1) mod 4 of group g, in lanes 0 and 1. It loads words (s+2) and (s+3) mod 4 on edge E+2. rvalid_o is 1 in both of those cycles.
- R4: A read or write strobe that is low on the edge right after the same kind of request was accepted is ignored. A request two edges after acceptance is accepted, so bursts of one kind can run back to back.
- R5: When both strobes are low on an edge where the read is accepted, the write is dropped and the array is unchanged.
- R6: wr_be_ni bit 2*l+h, when 0, writes half h of lane l: half 0 is bits [8:0] of the word and half 1 is bits [17:9]. When the bit is 1, that half of the stored word is kept. The enables are sampled with each data beat and may differ between the two beats.
- R7: In every cycle in which no read beat is being delivered, rvalid_o is 0 and rdata_o is zero. This covers the cycle right after a burst ends with no new read.
- R8: A read beat returns the stored contents as of the edge that loads it, merged with any write beat landing on that same edge under its half-word enables. A read accepted one edge after a write to the same group returns every word of that write.
- R9: Read and write bursts run at the same time and do not affect each other, apart from the sharing described in R5 and R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; both ports transfer two words per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of sequencers and output |
| rd_req_ni | input | 1 | Active-low read request |
| wr_req_ni | input | 1 | Active-low write request |
| addr_i | input | ADDR_W | Shared address: {group, start word} |
| wdata_i | input | 2*WORD_W | Write data, lane 0 in the low word |
| wr_be_ni | input | 4 | Active-low half-word write enables, bit 2*lane+half |
| rdata_o | output | 2*WORD_W | Read data, lane 0 in the low word |
| rvalid_o | output | 1 | Read data valid; low means the output is disabled |

## Verification
A write accepted on edge E takes its two data beats from the inputs held before edges E+1 and E+2. A read accepted on edge E shows its first word pair after edge E+1 and its second pair after edge E+2. The output returns to zero after E+3 unless another read follows. The bench drives inputs on the falling edge and keeps a reference model that advances on each rising edge using exactly these offsets. After every rising edge, it compares rvalid_o and rdata_o on the following falling edge against the model, so each result is checked in the cycle it is due and never one cycle early or late.

// File: rtl/qdr4_pkg.sv
package qdr4_pkg;
  localparam int unsigned LANES     = 2;
  localparam int unsigned BURST_LEN = 4;
  localparam int unsigned OFF_W     = $clog2(BURST_LEN);
  localparam int unsigned HALVES    = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_BEAT0 = 2'd1,
    SEQ_BEAT1 = 2'd2
  } seq_state_e;
endpackage

// File: rtl/qdr4_burst_seq.sv
module qdr4_burst_seq
  import qdr4_pkg::*;
#(
  parameter int unsigned BASE_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      hold_i,
  input  logic [BASE_W+OFF_W-1:0]   addr_i,
  output logic                      acc_o,
  output logic                      act_o,
  output logic [BASE_W-1:0]         base_o,
  output logic [LANES*OFF_W-1:0]    word_o
);
  seq_state_e        state_q, state_d;
  logic [BASE_W-1:0] base_q;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  beat_off;

  // the edge right after an accept is blind to new requests
  assign acc_o = req_i && !hold_i && (state_q != SEQ_BEAT0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  state_d = acc_o ? SEQ_BEAT0 : SEQ_IDLE;
      SEQ_BEAT0: state_d = SEQ_BEAT1;
      SEQ_BEAT1: state_d = acc_o ? SEQ_BEAT0 : SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      base_q  <= '0;
      off_q   <= '0;
    end else begin
      state_q <= state_d;
      if (acc_o) begin
        base_q <= addr_i[BASE_W+OFF_W-1:OFF_W];
        off_q  <= addr_i[OFF_W-1:0];
      end
    end
  end

  assign act_o    = (state_q != SEQ_IDLE);
  assign base_o   = base_q;
  assign beat_off = (state_q == SEQ_BEAT1) ? OFF_W'(LANES) : '0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign word_o[l*OFF_W +: OFF_W] = off_q + beat_off + OFF_W'(l);
  end
endmodule

// File: rtl/qdr4_store.sv
module qdr4_store
  import qdr4_pkg::*;
#(
  parameter int unsigned WORD_W = 18,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned BASE_W = $clog2(DEPTH),
  localparam int unsigned HALF_W = WORD_W / HALVES,
  localparam int unsigned WORDS  = DEPTH * BURST_LEN
) (
  input  logic                       clk_i,
  input  logic                       we_i,
  input  logic [BASE_W-1:0]          wbase_i,
  input  logic [LANES*OFF_W-1:0]     wword_i,
  input  logic [LANES*WORD_W-1:0]    wdata_i,
  input  logic [LANES*HALVES-1:0]    wmask_ni,
  input  logic [BASE_W-1:0]          rbase_i,
  input  logic [LANES*OFF_W-1:0]     rword_i,
  output logic [LANES*WORD_W-1:0]    rdata_o
);
  logic [WORD_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int l = 0; l < LANES; l++) begin
        for (int h = 0; h < HALVES; h++) begin
          if (!wmask_ni[l*HALVES+h]) begin
            mem_q[{wbase_i, wword_i[l*OFF_W +: OFF_W]}][h*HALF_W +: HALF_W]
              <= wdata_i[l*WORD_W + h*HALF_W +: HALF_W];
          end
        end
      end
    end
  end

  // same-edge write beats override the stored word per half
  for (genvar rl = 0; rl < LANES; rl++) begin : g_rd
    logic [WORD_W-1:0] raw_w;
    logic [WORD_W-1:0] fwd_w;

    assign raw_w = mem_q[{rbase_i, rword_i[rl*OFF_W +: OFF_W]}];

    always_comb begin
      fwd_w = raw_w;
      for (int wl = 0; wl < LANES; wl++) begin
        if (we_i && (wbase_i == rbase_i) &&
            (wword_i[wl*OFF_W +: OFF_W] == rword_i[rl*OFF_W +: OFF_W])) begin
          for (int h = 0; h < HALVES; h++) begin
            if (!wmask_ni[wl*HALVES+h]) begin
              fwd_w[h*HALF_W +: HALF_W] = wdata_i[wl*WORD_W + h*HALF_W +: HALF_W];
            end
          end
        end
      end
    end

    assign rdata_o[rl*WORD_W +: WORD_W] = fwd_w;
  end
endmodule

// File: rtl/qdr4_burst_mem.sv
module qdr4_burst_mem
  import qdr4_pkg::*;
#(
  parameter int unsigned WORD_W = 18,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned BASE_W = $clog2(DEPTH),
  localparam int unsigned ADDR_W = BASE_W + OFF_W,
  localparam int unsigned BUS_W  = LANES * WORD_W,
  localparam int unsigned BE_W   = LANES * HALVES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_ni,
  input  logic              wr_req_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [BE_W-1:0]   wr_be_ni,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              rvalid_o
);
  logic                   rd_acc, rd_act;
  logic [BASE_W-1:0]      rd_base;
  logic [LANES*OFF_W-1:0] rd_word;
  logic                   wr_acc, wr_act;
  logic [BASE_W-1:0]      wr_base;
  logic [LANES*OFF_W-1:0] wr_word;
  logic [BUS_W-1:0]       rd_lanes;
  logic [BUS_W-1:0]       rdata_q;
  logic                   rvalid_q;

  qdr4_burst_seq #(.BASE_W(BASE_W)) rd_seq_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (!rd_req_ni),
    .hold_i (1'b0),
    .addr_i (addr_i),
    .acc_o  (rd_acc),
    .act_o  (rd_act),
    .base_o (rd_base),
    .word_o (rd_word)
  );

  // read owns the shared address when both strobes are low
  qdr4_burst_seq #(.BASE_W(BASE_W)) wr_seq_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (!wr_req_ni),
    .hold_i (rd_acc),
    .addr_i (addr_i),
    .acc_o  (wr_acc),
    .act_o  (wr_act),
    .base_o (wr_base),
    .word_o (wr_word)
  );

  qdr4_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) store_i (
    .clk_i    (clk_i),
    .we_i     (wr_act),
    .wbase_i  (wr_base),
    .wword_i  (wr_word),
    .wdata_i  (wdata_i),
    .wmask_ni (wr_be_ni),
    .rbase_i  (rd_base),
    .rword_i  (rd_word),
    .rdata_o  (rd_lanes)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_act;
      rdata_q  <= rd_act ? rd_lanes : '0;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/qdr4_burst_mem_chk.sv
module qdr4_burst_mem_chk #(
  parameter int unsigned BUS_W = 36
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_req_ni,
  input logic             wr_req_ni,
  input logic [BUS_W-1:0] rdata_o,
  input logic             rvalid_o,
  input logic             rd_acc,
  input logic             wr_acc
);
  // R1
  r1_reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!rvalid_o && rdata_o == '0));

  // R3
  r3_first_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc |=> ##1 rvalid_o);

  // R3
  r3_second_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc |=> ##2 rvalid_o);

  // R4
  r4_rd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc |=> !rd_acc);

  // R4
  r4_wr_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc |=> !wr_acc);

  // R5
  r5_read_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_req_ni && !wr_req_ni && rd_acc) |-> !wr_acc);

  // R7
  r7_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0));

  // R7
  r7_valid_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> ($past(rd_acc, 2) || $past(rd_acc, 3)));
endmodule

bind qdr4_burst_mem qdr4_burst_mem_chk #(.BUS_W(BUS_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_req_ni (rd_req_ni),
  .wr_req_ni (wr_req_ni),
  .rdata_o   (rdata_o),
  .rvalid_o  (rvalid_o),
  .rd_acc    (rd_acc),
  .wr_acc    (wr_acc)
);

// File: tb/qdr4_burst_mem_tb_top.sv
module qdr4_burst_mem_tb_top;
  localparam int W  = 18;
  localparam int HW = 9;
  localparam int D  = 4;
  localparam int AW = 4;
  localparam int BW = 2 * W;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          rd_req_ni, wr_req_ni;
  logic [AW-1:0] addr_i;
  logic [BW-1:0] wdata_i;
  logic [3:0]    wr_be_ni;
  logic [BW-1:0] rdata_o;
  logic          rvalid_o;

  always #4 clk_i = ~clk_i;

  qdr4_burst_mem #(.WORD_W(W), .DEPTH(D)) dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_req_ni (rd_req_ni),
    .wr_req_ni (wr_req_ni),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .wr_be_ni  (wr_be_ni),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  int          checks = 0;
  int          fails  = 0;
  string       cur_req = "R1";
  bit          done = 1'b0;
  logic [31:0] seed = 32'h1d2c_3b4a;

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // reference model: advances on each rising edge from the requirement timing
  logic [W-1:0]  mm [16];
  int            r_left, w_left, beat, k;
  logic [1:0]    r_g, r_s, w_g, w_s;
  logic          rbusy, wbusy, racc, wacc;
  logic          exp_v;
  logic [BW-1:0] exp_d;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_left = 0; w_left = 0; exp_v = 1'b0; exp_d = '0;
    end else begin
      rbusy = (r_left == 2);
      wbusy = (w_left == 2);
      if (w_left > 0) begin
        beat = 2 - w_left;
        for (int l = 0; l < 2; l++) begin
          k = (int'(w_s) + 2 * beat + l) % 4;
          for (int h = 0; h < 2; h++)
            if (!wr_be_ni[2*l+h]) mm[int'(w_g)*4+k][h*HW +: HW] = wdata_i[l*W + h*HW +: HW];
        end
        w_left = w_left - 1;
      end
      if (r_left > 0) begin
        beat = 2 - r_left;
        for (int l = 0; l < 2; l++) begin
          k = (int'(r_s) + 2 * beat + l) % 4;
          exp_d[l*W +: W] = mm[int'(r_g)*4+k];
        end
        exp_v  = 1'b1;
        r_left = r_left - 1;
      end else begin
        exp_v = 1'b0;
        exp_d = '0;
      end
      racc = !rd_req_ni && !rbusy;
      wacc = !wr_req_ni && !wbusy && !racc;
      if (racc) begin r_left = 2; r_g = addr_i[3:2]; r_s = addr_i[1:0]; end
      if (wacc) begin w_left = 2; w_g = addr_i[3:2]; w_s = addr_i[1:0]; end
    end
  end

  task automatic compare();
    checks++;
    if (rvalid_o !== exp_v || rdata_o !== exp_d) begin
      fails++;
      $display("FAIL %s: actual valid=%0b data=%h expected valid=%0b data=%h",
               cur_req, rvalid_o, rdata_o, exp_v, exp_d);
    end
  endtask

  task automatic step(input logic rd_n, input logic wr_n, input logic [3:0] a,
                      input logic [3:0] be);
    @(negedge clk_i);
    compare();
    rd_req_ni = rd_n;
    wr_req_ni = wr_n;
    addr_i    = a;
    wr_be_ni  = be;
    wdata_i   = {rnd(), rnd()} & {BW{1'b1}};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 4'd0, 4'hF);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    rst_ni = 1'b0; rd_req_ni = 1'b1; wr_req_ni = 1'b1;
    addr_i = '0; wdata_i = '0; wr_be_ni = 4'hF;
    // R1: quiet output during and after reset
    cur_req = "R1";
    for (int i = 0; i < 3; i++) begin @(negedge clk_i); compare(); end
    rst_ni = 1'b1;
    idle(4);

    // R2: fill every group with back-to-back full writes
    cur_req = "R2";
    for (int g = 0; g < 4; g++) begin
      step(1'b1, 1'b0, 4'(g*4), 4'h0);
      step(1'b1, 1'b1, 4'd0, 4'h0);
    end
    step(1'b1, 1'b1, 4'd0, 4'h0);
    idle(3);

    // R3 and R7: read from every start word, one idle gap between bursts
    cur_req = "R3";
    for (int a = 0; a < 16; a++) begin
      step(1'b0, 1'b1, 4'(a), 4'hF);
      idle(2);
    end
    cur_req = "R7";
    idle(3);

    // R6: every enable pattern, complementary on the second beat
    cur_req = "R6";
    for (int m = 0; m < 16; m++) begin
      step(1'b1, 1'b0, 4'(m), 4'hF);
      step(1'b1, 1'b1, 4'd0, 4'(m));
      step(1'b1, 1'b1, 4'd0, 4'(m ^ 15));
      step(1'b0, 1'b1, 4'(m), 4'hF);
      idle(3);
    end

    // R4: strobes held low, accepted only every second edge
    cur_req = "R4";
    for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 4'(i), 4'hF);
    idle(3);
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 4'(15 - i), 4'(i));
    idle(3);
    for (int a = 0; a < 16; a += 4) begin step(1'b0, 1'b1, 4'(a), 4'hF); idle(2); end

    // R5: both strobes low, read first; write takes the free edges
    cur_req = "R5";
    step(1'b0, 1'b0, 4'd5, 4'h0);
    idle(3);
    step(1'b0, 1'b1, 4'd4, 4'hF);
    idle(3);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 4'(i * 3), 4'(i));
    idle(3);
    for (int a = 0; a < 16; a += 4) begin step(1'b0, 1'b1, 4'(a), 4'hF); idle(2); end

    // R8: read right after write, and read right before write
    cur_req = "R8";
    for (int wa = 0; wa < 16; wa++) begin
      for (int d = 0; d < 3; d++) begin
        step(1'b1, 1'b0, 4'(wa), 4'hF);
        step(1'b0, 1'b1, 4'(wa ^ d), 4'(wa));
        step(1'b1, 1'b1, 4'd0, 4'(d));
        idle(3);
        step(1'b0, 1'b1, 4'(wa ^ d), 4'hF);
        step(1'b1, 1'b0, 4'(wa), 4'hF);
        step(1'b1, 1'b1, 4'd0, 4'(d * 5));
        step(1'b1, 1'b1, 4'd0, 4'(wa));
        idle(3);
      end
    end

    // R9: overlapping random traffic
    cur_req = "R9";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = rnd();
      step(r[1:0] == 2'b00 ? 1'b1 : 1'b0, r[3:2] == 2'b00 ? 1'b1 : 1'b0,
           r[7:4], r[11:8]);
    end
    idle(4);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL %s: actual=watchdog timeout expected=run complete", cur_req);
      summary();
      $finish;
    end
  end
endmodule